// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each time a channel reports an expiry, the router forwards it in one of three ways. It can drive one of the interrupt lines at a level that stays up until software clears it. It can drive one of those lines for a single cycle. It can raise a 32-bit message write built from a per-channel 64-bit route register. The router also passes an external real-time-clock interrupt level onto a shared line and keeps a status bit for each channel that uses level delivery.

A legacy override pins channel 0 to line 0 and channel 1 to the same line the real-time-clock input uses. While the override is active, that clock input is kept off the line but its level is still recorded, so the line takes back the recorded level as soon as the override ends. Message writes leave through a valid/ready handshake. Each channel has a one-deep slot, and the lowest-numbered waiting channel is presented first.

Top module: `tmr_irq_router`

## Requirements
- R1: With the legacy override off, a delivered expiry of channel i drives the line whose index is that channel's route field, `route_i[i*RT_W +: RT_W]`.
- R2: With `legacy_i` high, channel 0 drives line 0 and channel 1 drives line `RTC_LINE` (default 8), whatever their route fields hold. Every other channel keeps using its route field.
- R3: A delivered expiry of a level channel (`lvl_i[i]`=1) sets `status_o[i]` on the next clock edge. The routed line stays high until a `clr_i[i]` pulse clears the bit. When an expiry and a clear arrive in the same cycle, the expiry wins.
- R4: A delivered expiry of an edge channel (`lvl_i[i]`=0) drives its line high for exactly one cycle, starting after the next clock edge, and leaves `status_o[i]` at 0.
- R5: An expiry that arrives while `tmr_en_i[i]` or `glb_en_i` is low drives no line and clears `status_o[i]`.
- R6: With `msg_en_i[i]` high, a delivered expiry drives no line and sets no status bit. Two clock edges later it presents `msg_valid_o` with `msg_addr_o` = `msg_reg_i[i*64+32 +: 32]` (the upper half) and `msg_data_o` = `msg_reg_i[i*64 +: 32]` (the lower half), both captured at the expiry.
- R7: When `msg_en_i[i]` goes from 0 to 1, `status_o[i]` is cleared on the next edge, and the level line that bit was driving drops at once.
- R8: `msg_valid_o`, `msg_addr_o` and `msg_data_o` hold steady until `msg_ready_i` is seen high at a clock edge. A channel that already has a write waiting or on the port loses any further expiry.
- R9: When several channels have writes waiting, the lowest-numbered one is presented first. A new write can be loaded on the same edge that accepts the previous one.
- R10: The `rtc_lvl_i` level is registered every cycle. It drives line `RTC_LINE` only while `legacy_i` is low. Setting `legacy_i` removes it from that line at once. Clearing `legacy_i` puts the recorded level back on the line.
- R11: After reset, `irq_o`, `status_o` and `msg_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | N_TMR | Per-channel expiry pulse |
| clr_i | input | N_TMR | Per-channel status clear pulse |
| tmr_en_i | input | N_TMR | Per-channel enable |
| lvl_i | input | N_TMR | 1 = level delivery, 0 = edge delivery |
| msg_en_i | input | N_TMR | Per-channel message delivery select |
| route_i | input | N_TMR*RT_W | Per-channel line index |
| msg_reg_i | input | N_TMR*64 | Per-channel message route register {address, data} |
| glb_en_i | input | 1 | Block-wide enable |
| legacy_i | input | 1 | Legacy override select |
| rtc_lvl_i | input | 1 | External real-time-clock interrupt level |
| msg_ready_i | input | 1 | Message write accepted |
| irq_o | output | N_LINE | Interrupt line vector |
| status_o | output | N_TMR | Level status, indexed by channel |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The routing function is driven from a table that varies the channel, the override and the delivery type. Each entry shows whether the line index comes from the route field or from the fixed legacy map, and whether a level or a one-cycle edge comes out. Directed tests then cover:
- expiries on disabled channels and at block level
- an expiry and a clear arriving together
- message writes: one held under back-pressure, a second one dropped, and two channels waiting at once to show the ordering
- real-time-clock levels changed while the override is on, to show the recorded value comes back when it ends

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int MSG_HW = 32;
  localparam int MSG_W  = 2 * MSG_HW;

  typedef struct packed {
    logic [MSG_HW-1:0] addr;
    logic [MSG_HW-1:0] data;
  } msg_t;
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  input  logic tmr_en_i,
  input  logic glb_en_i,
  input  logic lvl_i,
  input  logic msg_en_i,
  output logic status_o,
  output logic pulse_o,
  output logic hold_o,
  output logic msg_req_o
);
  logic act, men_rise;
  logic stat_q, stat_n, stat_en;
  logic pulse_q, pulse_n;
  logic men_q;

  assign act      = fire_i & tmr_en_i & glb_en_i;
  assign men_rise = msg_en_i & ~men_q;

  always_comb begin
    stat_n  = stat_q;
    stat_en = 1'b0;
    if (clr_i || (fire_i && !act) || men_rise) begin
      stat_n  = 1'b0;
      stat_en = 1'b1;
    end
    if (act && lvl_i && !msg_en_i) begin
      stat_n  = 1'b1;
      stat_en = 1'b1;
    end
    pulse_n = act & ~lvl_i & ~msg_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
      men_q   <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_n;
      pulse_q <= pulse_n;
      men_q   <= msg_en_i;
    end
  end

  assign status_o  = stat_q;
  assign pulse_o   = pulse_q;
  assign hold_o    = stat_q & lvl_i & ~msg_en_i;
  assign msg_req_o = act & msg_en_i;
endmodule

// File: rtl/tmr_irq_msg_arb.sv
module tmr_irq_msg_arb
  import tmr_irq_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  msg_t [N-1:0] pay_i,
  input  logic         ready_i,
  output logic         valid_o,
  output msg_t         pay_o
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] pend_q, pend_n, busy, take, sel_oh;
  msg_t [N-1:0] slot_q;
  logic [SW-1:0] src_q, src_n, sel;
  logic          valid_q, valid_n, load;
  msg_t          out_q, out_n;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      busy[i] = pend_q[i] | (valid_q && (src_q == SW'(i)));
    end
    take = req_i & ~busy;
    sel  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = SW'(i);
    end
    load    = (!valid_q || ready_i) && (|pend_q);
    sel_oh  = load ? (N'(1) << sel) : '0;
    pend_n  = (pend_q | take) & ~sel_oh;
    valid_n = load ? 1'b1 : (ready_i ? 1'b0 : valid_q);
    out_n   = load ? slot_q[sel] : out_q;
    src_n   = load ? sel : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
      src_q   <= '0;
      slot_q  <= '0;
    end else begin
      pend_q  <= pend_n;
      valid_q <= valid_n;
      if (load) begin
        out_q <= out_n;
        src_q <= src_n;
      end
      for (int i = 0; i < N; i++) begin
        if (take[i]) slot_q[i] <= pay_i[i];
      end
    end
  end

  assign valid_o = valid_q;
  assign pay_o   = out_q;
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int N_TMR    = 3,
  parameter int N_LINE   = 24,
  parameter int RT_W     = 5,
  parameter int RTC_LINE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TMR-1:0]        fire_i,
  input  logic [N_TMR-1:0]        clr_i,
  input  logic [N_TMR-1:0]        tmr_en_i,
  input  logic [N_TMR-1:0]        lvl_i,
  input  logic [N_TMR-1:0]        msg_en_i,
  input  logic [N_TMR*RT_W-1:0]   route_i,
  input  logic [N_TMR*MSG_W-1:0]  msg_reg_i,
  input  logic                    glb_en_i,
  input  logic                    legacy_i,
  input  logic                    rtc_lvl_i,
  input  logic                    msg_ready_i,
  output logic [N_LINE-1:0]       irq_o,
  output logic [N_TMR-1:0]        status_o,
  output logic                    msg_valid_o,
  output logic [MSG_HW-1:0]       msg_addr_o,
  output logic [MSG_HW-1:0]       msg_data_o
);
  logic [N_TMR-1:0]            pulse, hold, msg_req;
  logic [N_TMR-1:0][RT_W-1:0]  eff_line;
  msg_t [N_TMR-1:0]            pay;
  msg_t                        pay_out;
  logic                        rtc_q;
  logic [N_LINE-1:0]           irq_n;

  for (genvar i = 0; i < N_TMR; i++) begin : g_chan
    tmr_irq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire_i[i]),
      .clr_i     (clr_i[i]),
      .tmr_en_i  (tmr_en_i[i]),
      .glb_en_i  (glb_en_i),
      .lvl_i     (lvl_i[i]),
      .msg_en_i  (msg_en_i[i]),
      .status_o  (status_o[i]),
      .pulse_o   (pulse[i]),
      .hold_o    (hold[i]),
      .msg_req_o (msg_req[i])
    );

    assign pay[i] = msg_reg_i[i*MSG_W +: MSG_W];

    if (i == 0) begin : g_leg0
      assign eff_line[i] = legacy_i ? '0 : route_i[i*RT_W +: RT_W];
    end else if (i == 1) begin : g_leg1
      assign eff_line[i] = legacy_i ? RT_W'(RTC_LINE) : route_i[i*RT_W +: RT_W];
    end else begin : g_own
      assign eff_line[i] = route_i[i*RT_W +: RT_W];
    end
  end

  tmr_irq_msg_arb #(.N(N_TMR)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (msg_req),
    .pay_i   (pay),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .pay_o   (pay_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtc_q <= 1'b0;
    else        rtc_q <= rtc_lvl_i;
  end

  always_comb begin
    irq_n = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if ((hold[i] || pulse[i]) && (int'(eff_line[i]) < N_LINE)) irq_n[eff_line[i]] = 1'b1;
    end
    if (rtc_q && !legacy_i) irq_n[RTC_LINE] = 1'b1;
  end

  assign irq_o      = irq_n;
  assign msg_addr_o = pay_out.addr;
  assign msg_data_o = pay_out.data;
endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk #(
  parameter int N_TMR    = 3,
  parameter int N_LINE   = 24,
  parameter int RTC_LINE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_TMR-1:0]  fire_i,
  input logic [N_TMR-1:0]  clr_i,
  input logic              legacy_i,
  input logic              rtc_lvl_i,
  input logic              msg_ready_i,
  input logic [N_LINE-1:0] irq_o,
  input logic [N_TMR-1:0]  status_o,
  input logic              msg_valid_o,
  input logic [31:0]       msg_addr_o,
  input logic [31:0]       msg_data_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  // R10
  rtc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !legacy_i && $past(rtc_lvl_i)) |-> irq_o[RTC_LINE]);

  // R3
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~fire_i)) |=> ((status_o & $past(clr_i & ~fire_i)) == '0));

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((status_o & ~$past(status_o) & ~$past(fire_i)) == '0));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!msg_valid_o && (status_o == '0)));
endmodule

bind tmr_irq_router tmr_irq_router_chk #(
  .N_TMR(N_TMR), .N_LINE(N_LINE), .RTC_LINE(RTC_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .clr_i(clr_i),
  .legacy_i(legacy_i), .rtc_lvl_i(rtc_lvl_i), .msg_ready_i(msg_ready_i),
  .irq_o(irq_o), .status_o(status_o), .msg_valid_o(msg_valid_o),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
);

// File: tb/tb_tmr_irq_router.sv
`timescale 1ns/1ps
module tb_tmr_irq_router;
  localparam int N = 3, NL = 24, RW = 5, RL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] fire, clr, ten, lvl, men;
  logic [N*RW-1:0] route;
  logic [N*64-1:0] mreg;
  logic glb, leg, rtc, rdy;
  logic [NL-1:0] irq;
  logic [N-1:0] stat;
  logic mval;
  logic [31:0] maddr, mdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_irq_router dut (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(clr), .tmr_en_i(ten),
    .lvl_i(lvl), .msg_en_i(men), .route_i(route), .msg_reg_i(mreg),
    .glb_en_i(glb), .legacy_i(leg), .rtc_lvl_i(rtc), .msg_ready_i(rdy),
    .irq_o(irq), .status_o(stat), .msg_valid_o(mval),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  // {channel[2], legacy, level, route[5], expected line[5]}
  localparam logic [13:0] VEC [0:5] = '{
    {2'd0, 1'b0, 1'b1, 5'd5,  5'd5},
    {2'd1, 1'b0, 1'b0, 5'd12, 5'd12},
    {2'd0, 1'b1, 1'b1, 5'd5,  5'd0},
    {2'd1, 1'b1, 1'b0, 5'd12, 5'd8},
    {2'd2, 1'b1, 1'b1, 5'd17, 5'd17},
    {2'd2, 1'b0, 1'b0, 5'd23, 5'd23}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire1(input int t);
    fire[t] = 1'b1; tick(); fire = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    fire = '0; clr = '0; ten = '1; lvl = '0; men = '0; route = '0; mreg = '0;
    glb = 1'b1; leg = 1'b0; rtc = 1'b0; rdy = 1'b0;
    repeat (3) tick();
    // R11 reset state
    chk(irq == '0 && stat == '0 && !mval, "R11", {irq, stat, mval}, 0);
    rst_n = 1'b1;
    tick();

    // routing table
    for (int v = 0; v < 6; v++) begin
      automatic int t = int'(VEC[v][13:12]);
      automatic logic [NL-1:0] e = NL'(1) << VEC[v][4:0];
      leg = VEC[v][11];
      lvl[t] = VEC[v][10];
      route[t*RW +: RW] = VEC[v][9:5];
      tick();
      fire1(t);
      chk(irq == e, leg ? "R2" : "R1", irq, e);
      if (lvl[t]) begin
        chk(stat == (N'(1) << t), "R3 set", stat, N'(1) << t);
        tick();
        chk(irq == e, "R3 hold", irq, e);
        clr[t] = 1'b1; tick(); clr = '0;
        chk(irq == '0 && stat == '0, "R3 clear", {irq, stat}, 0);
      end else begin
        chk(stat == '0, "R4 status", stat, 0);
        tick();
        chk(irq == '0, "R4 one cycle", irq, 0);
      end
    end
    leg = 1'b0;

    // R5 disabled channel / block
    lvl = '1; route[0 +: RW] = 5'd3;
    fire1(0);
    chk(stat[0] && irq[3], "R5 setup", {stat, irq}, 1);
    ten[0] = 1'b0; fire1(0);
    chk(stat == '0 && irq == '0, "R5 channel off", {stat, irq}, 0);
    ten[0] = 1'b1; glb = 1'b0; fire1(0);
    chk(stat == '0 && irq == '0, "R5 block off", {stat, irq}, 0);
    glb = 1'b1;

    // R3 expiry wins over simultaneous clear
    fire1(0);
    fire[0] = 1'b1; clr[0] = 1'b1; tick(); fire = '0; clr = '0;
    chk(stat[0] == 1'b1, "R3 fire beats clear", stat, 1);
    clr[0] = 1'b1; tick(); clr = '0;

    // R7 enabling messages clears pending status
    route[2*RW +: RW] = 5'd4;
    fire1(2);
    chk(stat[2] && irq[4], "R7 setup", {stat, irq}, 1);
    men[2] = 1'b1; #1;
    chk(irq == '0, "R7 line drops", irq, 0);
    tick();
    chk(stat == '0, "R7 status", stat, 0);

    // R6 message write
    mreg[2*64 +: 64] = {32'hA5A5_0010, 32'h0000_0042};
    fire1(2);
    chk(!mval && irq == '0 && stat == '0, "R6 no line", {mval, irq, stat}, 0);
    tick();
    chk(mval && maddr == 32'hA5A5_0010 && mdata == 32'h0000_0042, "R6 payload", {maddr, mdata}, {32'hA5A5_0010, 32'h42});

    // R8 hold under back-pressure, extra fire dropped
    mreg[2*64 +: 64] = {32'hBEEF_0020, 32'h0000_0077};
    fire1(2);
    tick();
    chk(mval && maddr == 32'hA5A5_0010 && mdata == 32'h42, "R8 hold", {maddr, mdata}, {32'hA5A5_0010, 32'h42});
    rdy = 1'b1; tick(); rdy = 1'b0;
    tick();
    chk(!mval, "R8 dropped", mval, 0);

    // R9 lowest channel first
    men[0] = 1'b1;
    mreg[0 +: 64] = {32'h1000_0000, 32'h0000_0001};
    fire[0] = 1'b1; fire[2] = 1'b1; tick(); fire = '0;
    tick();
    chk(mval && maddr == 32'h1000_0000, "R9 first", maddr, 32'h1000_0000);
    rdy = 1'b1; tick();
    chk(mval && maddr == 32'hBEEF_0020 && mdata == 32'h77, "R9 second", maddr, 32'hBEEF_0020);
    tick(); rdy = 1'b0;
    chk(!mval, "R9 empty", mval, 0);
    men = '0;

    // R10 real-time-clock pass-through
    rtc = 1'b1; tick();
    chk(irq[RL] == 1'b1, "R10 pass", irq, 1 << RL);
    leg = 1'b1; tick();
    chk(irq[RL] == 1'b0, "R10 gated", irq, 0);
    rtc = 1'b0; tick(); rtc = 1'b1; tick();
    leg = 1'b0; #1;
    chk(irq[RL] == 1'b1, "R10 restore high", irq, 1 << RL);
    leg = 1'b1; rtc = 1'b0; tick();
    leg = 1'b0; #1;
    chk(irq[RL] == 1'b0, "R10 restore low", irq, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule